// File: doc/BRIEF.md
# Dual-Pack Charge Sequencer

This block shares one charging resource between two battery channels, A (index 0) and B (index 1). Each channel has its own charge controller, which does the threshold checks, detects termination and drives the pulses. The controllers report to this block through per-channel presence levels, insertion pulses and completion flags. The sequencer keeps a phase for each channel: absent, discharging, waiting for fast charge, waiting for top-off, or maintenance. It holds a single active slot, and it grants fast charge or top-off only to the channel that owns that slot.

The scheme is a fixed priority, not a rotation. When both packs are present at a joint start, B fast-charges first. A fast phase, once granted, is never taken away by an insertion on the other channel. All top-off phases wait until every pending fast phase is done, and B goes first. A new insertion on the other channel cuts short a running top-off. Channel A may discharge before charging while B owns the slot. When that discharge ends, A waits as pending until the slot comes free. Maintenance charging needs no slot, so both channels can have it at once.

Every phase and the slot are registered. A pulse sampled at one rising edge changes the grants after that same edge. Removing a pack masks its grants at once.

Top module: `dual_pack_seq`

## Requirements
- R1: In every vector port, bit 0 is channel A and bit 1 is channel B. `slot_ch` is 0 for A and 1 for B, and it reads 0 while `slot_valid` is low. After synchronous reset, all grants, `pend`, `slot_valid` and `slot_ch` are 0.
- R2: A `cycle_start` pulse restarts every present channel from scratch and clears the slot. Channel A restarts in discharge if `auto_dis_a` is high; otherwise each channel waits for fast charge. If both channels wait for fast charge, B's fast grant appears after that edge.
- R3: A channel holding a fast grant keeps it until its own `fast_done`. An insertion on the other channel only makes the other channel pending.
- R4: When B's fast charge ends with `topoff_en` high, A's fast grant follows. Then B's top-off runs, then A's top-off, and each finished channel gets maintenance.
- R5: With `topoff_en` low, `fast_done` moves the channel straight to maintenance, and the slot passes to the next waiting channel.
- R6: An insertion on one channel while the other holds a top-off grant ends that top-off. The topped-off channel goes to maintenance, and the inserted channel gets a fast grant after the same edge.
- R7: `dis_cmd_a`, or a restart of A with `auto_dis_a` high, puts A in discharge. `dis_gnt_a` is then high whether or not B owns the slot. `dis_done_a` moves A to waiting for fast charge, shown by `pend[0]` while B keeps the slot.
- R8: At most one fast or top-off grant is high in any cycle, and only for the slot channel. Maintenance grants may be high on both channels together.
- R9: Dropping `present` of the slot channel drops its grants and `slot_valid` in the same cycle. A waiting channel receives the slot after the next edge.
- R10: A `fast_done` or `top_done` flag on a channel that does not hold the matching grant has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cycle_start | input | 1 | Pulse: supply became valid, new charge cycle on all channels |
| present | input | 2 | Level: pack present per channel |
| insert | input | 2 | Pulse: pack replaced per channel, restarts that channel |
| auto_dis_a | input | 1 | Level: A discharges first on every restart |
| dis_cmd_a | input | 1 | Pulse: start discharge on A |
| dis_done_a | input | 1 | Pulse: A discharge finished |
| topoff_en | input | 1 | Level: run a top-off phase after fast charge |
| fast_done | input | 2 | Pulse: fast charge terminated per channel |
| top_done | input | 2 | Pulse: top-off terminated per channel |
| slot_valid | output | 1 | The active slot is owned |
| slot_ch | output | 1 | Channel owning the slot |
| fast_gnt | output | 2 | Fast-charge grant per channel |
| top_gnt | output | 2 | Top-off grant per channel |
| maint_gnt | output | 2 | Maintenance grant per channel |
| dis_gnt_a | output | 1 | Discharge grant for A |
| pend | output | 2 | Channel waits for the slot |

## Verification
The hardest situation to reach is a top-off preemption. It needs both fast phases finished, B's top-off finished, and A holding the slot in top-off, all before a re-insertion on B. The bench gets there by walking a full joint-start sequence with done flags in the right order, and it puts stray done flags on the non-owning channel along the way. The discharge overlap is reached by restarting with `auto_dis_a` high and then inserting on B, so that B owns the slot while A is still discharging.

// File: rtl/dual_pack_seq_pkg.sv
package dual_pack_seq_pkg;

  typedef enum logic [2:0] {
    PH_ABSENT    = 3'd0,
    PH_DISCH     = 3'd1,
    PH_NEED_FAST = 3'd2,
    PH_NEED_TOP  = 3'd3,
    PH_MAINT     = 3'd4
  } phase_e;

  // a phase that competes for the shared slot
  function automatic logic wants_slot(phase_e ph);
    return (ph == PH_NEED_FAST) || (ph == PH_NEED_TOP);
  endfunction

  // fixed priority: fast before top-off, B before A; returns {valid, ch}
  function automatic logic [1:0] pick_slot(phase_e ph_a, phase_e ph_b);
    if (ph_b == PH_NEED_FAST)      return 2'b11;
    else if (ph_a == PH_NEED_FAST) return 2'b10;
    else if (ph_b == PH_NEED_TOP)  return 2'b11;
    else if (ph_a == PH_NEED_TOP)  return 2'b10;
    else                           return 2'b00;
  endfunction

endpackage

// File: rtl/dual_pack_chan.sv
module dual_pack_chan
  import dual_pack_seq_pkg::*;
#(
  parameter bit CAN_DISCH = 1'b0
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   present,
  input  logic   new_cycle,
  input  logic   insert,
  input  logic   other_insert,
  input  logic   auto_dis,
  input  logic   dis_cmd,
  input  logic   dis_done,
  input  logic   topoff_en,
  input  logic   fast_done,
  input  logic   top_done,
  input  logic   holds_slot,
  output phase_e ph_q,
  output phase_e ph_n
);

  logic restart_to_dis;
  logic in_fast_grant;
  logic in_top_grant;

  assign restart_to_dis = CAN_DISCH && auto_dis;
  assign in_fast_grant  = holds_slot && (ph_q == PH_NEED_FAST);
  assign in_top_grant   = holds_slot && (ph_q == PH_NEED_TOP);

  always_comb begin
    ph_n = ph_q;
    if (!present)
      ph_n = PH_ABSENT;
    else if (new_cycle || insert)
      ph_n = restart_to_dis ? PH_DISCH : PH_NEED_FAST;
    else if (CAN_DISCH && dis_cmd)
      ph_n = PH_DISCH;
    else if (in_top_grant && other_insert)
      ph_n = PH_MAINT;
    else if (in_fast_grant && fast_done)
      ph_n = topoff_en ? PH_NEED_TOP : PH_MAINT;
    else if (in_top_grant && top_done)
      ph_n = PH_MAINT;
    else if (ph_q == PH_DISCH && dis_done)
      ph_n = PH_NEED_FAST;
  end

  always_ff @(posedge clk) begin
    if (rst) ph_q <= PH_ABSENT;
    else     ph_q <= ph_n;
  end

endmodule

// File: rtl/dual_pack_slot.sv
module dual_pack_slot
  import dual_pack_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   new_cycle,
  input  phase_e ph_a_q,
  input  phase_e ph_b_q,
  input  phase_e ph_a_n,
  input  phase_e ph_b_n,
  output logic   v_q,
  output logic   ch_q
);

  phase_e     cur_q;
  phase_e     cur_n;
  logic       keep;
  logic [1:0] choice;

  assign cur_q  = ch_q ? ph_b_q : ph_a_q;
  assign cur_n  = ch_q ? ph_b_n : ph_a_n;
  assign keep   = v_q && !new_cycle && (cur_q == cur_n) && wants_slot(cur_n);
  assign choice = pick_slot(ph_a_n, ph_b_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q  <= 1'b0;
      ch_q <= 1'b0;
    end else if (!keep) begin
      v_q  <= choice[1];
      ch_q <= choice[1] & choice[0];
    end
  end

endmodule

// File: rtl/dual_pack_seq.sv
module dual_pack_seq
  import dual_pack_seq_pkg::*;
#(
  parameter logic [1:0] DIS_MASK = 2'b01
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cycle_start,
  input  logic [1:0] present,
  input  logic [1:0] insert,
  input  logic       auto_dis_a,
  input  logic       dis_cmd_a,
  input  logic       dis_done_a,
  input  logic       topoff_en,
  input  logic [1:0] fast_done,
  input  logic [1:0] top_done,
  output logic       slot_valid,
  output logic       slot_ch,
  output logic [1:0] fast_gnt,
  output logic [1:0] top_gnt,
  output logic [1:0] maint_gnt,
  output logic       dis_gnt_a,
  output logic [1:0] pend
);

  localparam int NCH = 2;

  phase_e ph_q [NCH];
  phase_e ph_n [NCH];
  logic   sv_q;
  logic   sc_q;
  logic [NCH-1:0] holds;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign holds[c] = sv_q && (sc_q == 1'(c));

    dual_pack_chan #(.CAN_DISCH(DIS_MASK[c])) u_chan (
      .clk          (clk),
      .rst          (rst),
      .present      (present[c]),
      .new_cycle    (cycle_start),
      .insert       (insert[c]),
      .other_insert (insert[NCH-1-c]),
      .auto_dis     (auto_dis_a),
      .dis_cmd      (dis_cmd_a),
      .dis_done     (dis_done_a),
      .topoff_en    (topoff_en),
      .fast_done    (fast_done[c]),
      .top_done     (top_done[c]),
      .holds_slot   (holds[c]),
      .ph_q         (ph_q[c]),
      .ph_n         (ph_n[c])
    );

    assign fast_gnt[c]  = present[c] && holds[c] && (ph_q[c] == PH_NEED_FAST);
    assign top_gnt[c]   = present[c] && holds[c] && (ph_q[c] == PH_NEED_TOP);
    assign maint_gnt[c] = present[c] && (ph_q[c] == PH_MAINT);
    assign pend[c]      = present[c] && !holds[c] && wants_slot(ph_q[c]);
  end

  dual_pack_slot u_slot (
    .clk       (clk),
    .rst       (rst),
    .new_cycle (cycle_start),
    .ph_a_q    (ph_q[0]),
    .ph_b_q    (ph_q[1]),
    .ph_a_n    (ph_n[0]),
    .ph_b_n    (ph_n[1]),
    .v_q       (sv_q),
    .ch_q      (sc_q)
  );

  // removal of the owner releases the slot in the same cycle
  assign slot_valid = sv_q && present[sc_q];
  assign slot_ch    = slot_valid && sc_q;
  assign dis_gnt_a  = present[0] && (ph_q[0] == PH_DISCH);

endmodule

// File: rtl/dual_pack_seq_chk.sv
module dual_pack_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       cycle_start,
  input logic [1:0] present,
  input logic [1:0] insert,
  input logic       auto_dis_a,
  input logic       dis_cmd_a,
  input logic       dis_done_a,
  input logic       topoff_en,
  input logic [1:0] fast_done,
  input logic [1:0] top_done,
  input logic       slot_valid,
  input logic       slot_ch,
  input logic [1:0] fast_gnt,
  input logic [1:0] top_gnt,
  input logic [1:0] maint_gnt,
  input logic       dis_gnt_a,
  input logic [1:0] pend
);

  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fast_gnt, top_gnt})); // R8

  AST_GRANT_OWNS_SLOT: assert property (@(posedge clk) disable iff (rst)
    (|{fast_gnt, top_gnt}) |-> (slot_valid && (slot_ch == (fast_gnt[1] | top_gnt[1])))); // R8

  AST_JOINT_START_B: assert property (@(posedge clk) disable iff (rst)
    (cycle_start && present == 2'b11) |=> (fast_gnt[1] || !present[1])); // R2

  AST_FAST_KEEP_B: assert property (@(posedge clk) disable iff (rst)
    (fast_gnt[1] && !fast_done[1] && !insert[1] && !cycle_start)
      |=> (fast_gnt[1] || !present[1])); // R3

  AST_FAST_KEEP_A: assert property (@(posedge clk) disable iff (rst)
    (fast_gnt[0] && !fast_done[0] && !insert[0] && !cycle_start && !dis_cmd_a)
      |=> (fast_gnt[0] || !present[0])); // R3

  AST_TOP_PREEMPT: assert property (@(posedge clk) disable iff (rst)
    (top_gnt[0] && insert[1] && present[1] && !insert[0] && !cycle_start && !dis_cmd_a)
      |=> (!top_gnt[0] && (fast_gnt[1] || !present[1]))); // R6

  AST_DIS_NO_CHARGE: assert property (@(posedge clk) disable iff (rst)
    dis_gnt_a |-> (!fast_gnt[0] && !top_gnt[0] && !maint_gnt[0])); // R7

  AST_ABSENT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (present != 2'b11) |-> (((fast_gnt | top_gnt | maint_gnt | pend) & ~present) == 2'b00)); // R9

  logic unused_ok;
  assign unused_ok = ^{auto_dis_a, dis_done_a, topoff_en, top_done};

endmodule

bind dual_pack_seq dual_pack_seq_chk u_chk (.*);

// File: tb/dual_pack_seq_bench.sv
module dual_pack_seq_bench;

  typedef struct packed {
    logic [1:0] fast;
    logic [1:0] top;
    logic [1:0] maint;
    logic       dis;
    logic [1:0] pend;
    logic       sv;
    logic       sc;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst;
  logic       cycle_start;
  logic [1:0] present;
  logic [1:0] insert;
  logic       auto_dis_a;
  logic       dis_cmd_a;
  logic       dis_done_a;
  logic       topoff_en;
  logic [1:0] fast_done;
  logic [1:0] top_done;
  logic       slot_valid;
  logic       slot_ch;
  logic [1:0] fast_gnt;
  logic [1:0] top_gnt;
  logic [1:0] maint_gnt;
  logic       dis_gnt_a;
  logic [1:0] pend;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  exp_t  exp_q[$];
  string tag_q[$];
  exp_t  mon_e;
  exp_t  mon_g;
  string mon_t;

  always #10 clk = ~clk;

  dual_pack_seq u_dual_pack_seq (
    .clk(clk), .rst(rst), .cycle_start(cycle_start), .present(present),
    .insert(insert), .auto_dis_a(auto_dis_a), .dis_cmd_a(dis_cmd_a),
    .dis_done_a(dis_done_a), .topoff_en(topoff_en), .fast_done(fast_done),
    .top_done(top_done), .slot_valid(slot_valid), .slot_ch(slot_ch),
    .fast_gnt(fast_gnt), .top_gnt(top_gnt), .maint_gnt(maint_gnt),
    .dis_gnt_a(dis_gnt_a), .pend(pend)
  );

  function automatic exp_t mk(logic [1:0] f, logic [1:0] t, logic [1:0] m,
                              logic d, logic [1:0] p, logic sv, logic sc);
    exp_t e;
    e.fast = f; e.top = t; e.maint = m; e.dis = d; e.pend = p; e.sv = sv; e.sc = sc;
    return e;
  endfunction

  task automatic chk(input string t, input logic [11:0] got, input logic [11:0] e);
    checks++;
    if (got !== e) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", t, got, e);
    end
  endtask

  // monitor: compares the scoreboard head against the outputs
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      mon_e = exp_q.pop_front();
      mon_t = tag_q.pop_front();
      mon_g = {fast_gnt, top_gnt, maint_gnt, dis_gnt_a, pend, slot_valid, slot_ch};
      chk(mon_t, mon_g, mon_e);
    end
  end

  // driver: one clock edge with the current inputs, then clear the pulses
  task automatic step(input string t, input exp_t e);
    @(posedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    #2;
    cycle_start = 1'b0; insert = 2'b00; dis_cmd_a = 1'b0; dis_done_a = 1'b0;
    fast_done = 2'b00; top_done = 2'b00;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst = 1'b1; cycle_start = 1'b0; present = 2'b00; insert = 2'b00;
    auto_dis_a = 1'b0; dis_cmd_a = 1'b0; dis_done_a = 1'b0; topoff_en = 1'b1;
    fast_done = 2'b00; top_done = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset state", {fast_gnt, top_gnt, maint_gnt, dis_gnt_a, pend, slot_valid, slot_ch}, 12'b0);
    #2;

    present = 2'b11; cycle_start = 1'b1;
    step("R2 joint start B first", mk(2'b10, 2'b00, 2'b00, 0, 2'b01, 1, 1));
    fast_done = 2'b01;
    step("R10 stray fast_done on A", mk(2'b10, 2'b00, 2'b00, 0, 2'b01, 1, 1));
    fast_done = 2'b10;
    step("R4 A fast after B", mk(2'b01, 2'b00, 2'b00, 0, 2'b10, 1, 0));
    top_done = 2'b01;
    step("R10 stray top_done on A", mk(2'b01, 2'b00, 2'b00, 0, 2'b10, 1, 0));
    fast_done = 2'b01;
    step("R4 B top-off first", mk(2'b00, 2'b10, 2'b00, 0, 2'b01, 1, 1));
    top_done = 2'b10;
    step("R4 A top-off then", mk(2'b00, 2'b01, 2'b10, 0, 2'b00, 1, 0));
    insert = 2'b10;
    step("R6 insertion on B preempts A top-off", mk(2'b10, 2'b00, 2'b01, 0, 2'b00, 1, 1));
    insert = 2'b01;
    step("R3 insertion on A waits", mk(2'b10, 2'b00, 2'b00, 0, 2'b01, 1, 1));

    present = 2'b01;
    #1;
    chk("R9 same-cycle release", {10'b0, fast_gnt[1], slot_valid}, 12'b0);
    step("R9 A granted after removal", mk(2'b01, 2'b00, 2'b00, 0, 2'b00, 1, 0));

    auto_dis_a = 1'b1; cycle_start = 1'b1;
    step("R7 restart into discharge", mk(2'b00, 2'b00, 2'b00, 1, 2'b00, 0, 0));
    present = 2'b11; insert = 2'b10;
    step("R7 discharge while B active", mk(2'b10, 2'b00, 2'b00, 1, 2'b00, 1, 1));
    dis_done_a = 1'b1;
    step("R7 A pending after discharge", mk(2'b10, 2'b00, 2'b00, 0, 2'b01, 1, 1));
    topoff_en = 1'b0; fast_done = 2'b10;
    step("R5 no top-off B to maint", mk(2'b01, 2'b00, 2'b10, 0, 2'b00, 1, 0));
    fast_done = 2'b01;
    step("R8 both maintenance", mk(2'b00, 2'b00, 2'b11, 0, 2'b00, 0, 0));
    dis_cmd_a = 1'b1;
    step("R7 discharge command", mk(2'b00, 2'b00, 2'b10, 1, 2'b00, 0, 0));

    @(negedge clk);
    finish_run();
  end

endmodule